// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

A byte-wide storage block whose top eight byte addresses hold a running time-of-day and calendar instead of memory. A prescaler divides the system clock into a once-per-second advance that drives packed-BCD counters for seconds, minutes, 24-hour hours, day of week, date, month and a two-digit year. Month lengths and leap Februaries are resolved in hardware.

The host never touches the live counters. It sees a shadow copy that follows them, can be frozen for a consistent multi-byte read, or can be opened for a full rewrite that is committed in one step. Counting carries on through all host traffic. A supply-fail input deselects the whole block. `ADDR_W` = 15 gives the full 32K x 8 map; the default is a smaller map with identical behaviour.

Top module: `bcd_clock_ram`

## Requirements
- R1: Addresses below the top eight are plain storage. A write happens on the clock edge when `ce_ni`=0 and `we_ni`=0. While `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, `rdata_o` shows the addressed byte combinationally. Otherwise `rdata_o` is 0.
- R2: The top eight addresses, from lowest to highest, are: control, seconds, minutes, hours, day of week (1..7), date, month, year. All values are packed BCD and hours run 00..23. In the control byte, bit 7 is the write hold and bit 6 is the read freeze; its other bits read 0. After reset the time is 00:00:00, day 1, 01/01/00, and the control byte is 0.
- R3: On an advance, seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into the day.
- R4: On a day carry, day of week 7 wraps to 1; any other value increments.
- R5: On a day carry, the date wraps to 01 and carries into the month only after the month's last day. January, March, May, July, August, October and December have 31 days; April, June, September and November have 30; February has 28.
- R6: February has 29 days when the BCD year is divisible by four, year 00 included.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R8: With both control bits clear, the visible registers follow the counters within one clock of every advance.
- R9: While the read freeze is set, the visible registers hold still and the counters keep advancing. After the freeze clears, reads show the elapsed time.
- R10: While the write hold is set, writes to the seven time registers land only in the visible copy. Clearing the hold loads that copy into the counters and restarts the prescaler. Time-register writes made while the hold is clear have no effect.
- R11: While seconds bit 7 (stop) is set in the counters, advances are ignored.
- R12: While `pwr_fail_i`=1, `rdata_o` is 0, and writes to storage and to all eight registers are ignored.
- R13: One advance occurs every `TICK_DIV` clocks. After a load, the first advance lands `TICK_DIV` clocks after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_fail_i | input | 1 | Supply out of tolerance; deselects the block |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not reading |

## Verification
The assertions check several properties on every cycle: seconds wrap and year wrap at the counter, the stop flag freezing the counters, the shadow following or holding according to the control bits, the prescaler restart, and the quiet bus under supply fail. Month lengths and leap Februaries for every month, day-of-week wrap, the timing of the first advance after a load, and the elapsed time seen after a frozen read can only be shown by the bench's scenarios. The same holds for storage contents and for writes that are ignored.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  typedef struct packed {
    logic [7:0] sec;   // bit 7 = stop
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
  } cal_t;

  localparam cal_t CAL_RST = '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                               date: 8'h01, mon: 8'h01, yr: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // divisible by 4: even tens -> units 0/4/8, odd tens -> units 2/6
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_clock_prescale.sv
module bcd_clock_prescale #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  a_r13_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !tick_o);

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_clock_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t cal_o
);
  cal_t cal_q, nxt;
  logic stop;

  assign stop = cal_q.sec[7];

  always_comb begin
    nxt = cal_q;
    if (cal_q.sec != 8'h59) nxt.sec = bcd_inc(cal_q.sec);
    else begin
      nxt.sec = 8'h00;
      if (cal_q.min != 8'h59) nxt.min = bcd_inc(cal_q.min);
      else begin
        nxt.min = 8'h00;
        if (cal_q.hr != 8'h23) nxt.hr = bcd_inc(cal_q.hr);
        else begin
          nxt.hr  = 8'h00;
          nxt.dow = (cal_q.dow == 8'h07) ? 8'h01 : cal_q.dow + 8'd1;
          if (cal_q.date != last_date(cal_q.mon, cal_q.yr)) nxt.date = bcd_inc(cal_q.date);
          else begin
            nxt.date = 8'h01;
            if (cal_q.mon != 8'h12) nxt.mon = bcd_inc(cal_q.mon);
            else begin
              nxt.mon = 8'h01;
              nxt.yr  = (cal_q.yr == 8'h99) ? 8'h00 : bcd_inc(cal_q.yr);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cal_q <= CAL_RST;
    else if (load_i)          cal_q <= load_val_i;
    else if (tick_i && !stop) cal_q <= nxt;
  end

  assign cal_o = cal_q;

  a_r11_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !load_i) |=> $stable(cal_q));

  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00));

  a_r7_year_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cal_q.sec == 8'h59 && cal_q.min == 8'h59 && cal_q.hr == 8'h23 &&
     cal_q.date == 8'h31 && cal_q.mon == 8'h12 && cal_q.yr == 8'h99)
    |=> (cal_q.yr == 8'h00) && (cal_q.mon == 8'h01) && (cal_q.date == 8'h01));

endmodule

// File: rtl/bcd_clock_store.sv
module bcd_clock_store #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/bcd_clock_ram.sv
module bcd_clock_ram
  import bcd_clock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_fail_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned HI_W = ADDR_W - 3;

  logic       sel, wr, rd, reg_sel, ctl_hit;
  logic [2:0] idx;
  logic       ctl_w_q, ctl_r_q;
  logic       load, tick;
  logic [7:0] mem_rdata, reg_byte;
  cal_t       cal, ubuf_q;

  assign sel     = !ce_ni && !pwr_fail_i;
  assign wr      = sel && !we_ni;
  assign rd      = sel && !oe_ni && we_ni;
  assign reg_sel = &addr_i[ADDR_W-1:3];
  assign idx     = addr_i[2:0];
  assign ctl_hit = wr && reg_sel && (idx == 3'd0);
  assign load    = ctl_hit && ctl_w_q && !wdata_i[7];

  bcd_clock_store #(.AW(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr && !reg_sel),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  bcd_clock_prescale #(.DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .tick_o (tick)
  );

  bcd_clock_calendar u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (ubuf_q),
    .cal_o      (cal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_w_q <= 1'b0;
      ctl_r_q <= 1'b0;
    end else if (ctl_hit) begin
      ctl_w_q <= wdata_i[7];
      ctl_r_q <= wdata_i[6];
    end
  end

  // shadow: follows counters when idle, host-writable only under write hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ubuf_q <= CAL_RST;
    else if (!ctl_w_q && !ctl_r_q) ubuf_q <= cal;
    else if (ctl_w_q && wr && reg_sel) begin
      case (idx)
        3'd1:    ubuf_q.sec  <= wdata_i;
        3'd2:    ubuf_q.min  <= wdata_i;
        3'd3:    ubuf_q.hr   <= wdata_i;
        3'd4:    ubuf_q.dow  <= wdata_i;
        3'd5:    ubuf_q.date <= wdata_i;
        3'd6:    ubuf_q.mon  <= wdata_i;
        3'd7:    ubuf_q.yr   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      3'd0:    reg_byte = {ctl_w_q, ctl_r_q, 6'b0};
      3'd1:    reg_byte = ubuf_q.sec;
      3'd2:    reg_byte = ubuf_q.min;
      3'd3:    reg_byte = ubuf_q.hr;
      3'd4:    reg_byte = ubuf_q.dow;
      3'd5:    reg_byte = ubuf_q.date;
      3'd6:    reg_byte = ubuf_q.mon;
      default: reg_byte = ubuf_q.yr;
    endcase
  end

  assign rdata_o = !rd ? 8'h00 : (reg_sel ? reg_byte : mem_rdata);

  a_r12_pf_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |-> (rdata_o == 8'h00));

  a_r12_pf_ctl_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> $stable(ctl_w_q) && $stable(ctl_r_q));

  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_r_q && !ctl_w_q) |=> $stable(ubuf_q));

  a_r8_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_w_q && !ctl_r_q) |=> (ubuf_q == $past(cal)));

  initial begin
    a_r2_map_room: assert (ADDR_W >= 4 && HI_W >= 1);
  end

endmodule

// File: tb/bcd_clock_ram_test.sv
module bcd_clock_ram_test;
  localparam int AW  = 11;
  localparam int DIV = 8;
  localparam logic [AW-1:0] A_CTL = 11'h7F8;
  localparam logic [AW-1:0] A_SEC = 11'h7F9;
  localparam logic [AW-1:0] A_MIN = 11'h7FA;
  localparam logic [AW-1:0] A_HR  = 11'h7FB;
  localparam logic [AW-1:0] A_DOW = 11'h7FC;
  localparam logic [AW-1:0] A_DAT = 11'h7FD;
  localparam logic [AW-1:0] A_MON = 11'h7FE;
  localparam logic [AW-1:0] A_YR  = 11'h7FF;

  logic clk = 1'b0, rst_n = 1'b0, pf = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int tests = 0, failed = 0;
  bit done = 0;

  bcd_clock_ram #(.ADDR_W(AW), .TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pf), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  always #10 clk = ~clk;

  function automatic logic [7:0] tob(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1 d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic set_time(input logic [7:0] y, mo, da, dw, h, mi, s);
    wr(A_CTL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_DOW, dw);
    wr(A_DAT, da); wr(A_MON, mo); wr(A_YR, y);
    wr(A_CTL, 8'h00);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // end-of-day case: one advance from 23:59:59 on (y,m,d,dw), frozen snapshot
  task automatic day_case(input int y, input int m, input int d, input int dw);
    int ny = y, nm = m, nd = d, ndw;
    ndw = (dw == 7) ? 1 : dw + 1;
    if (d == dim(m, y)) begin
      nd = 1;
      if (m == 12) begin nm = 1; ny = (y + 1) % 100; end
      else nm = m + 1;
    end else nd = d + 1;
    set_time(tob(y), tob(m), tob(d), tob(dw), 8'h23, 8'h59, 8'h59);
    wait_n(DIV + 1);
    wr(A_CTL, 8'h40);
    wait_n(2 * DIV);  // counters move on, snapshot must not
    rdchk("R3 sec", A_SEC, 8'h00);
    rdchk("R3 min", A_MIN, 8'h00);
    rdchk("R3 hr",  A_HR,  8'h00);
    rdchk("R4 dow", A_DOW, tob(ndw));
    rdchk((m == 2) ? "R6 date" : "R5 date", A_DAT, tob(nd));
    rdchk("R5 mon", A_MON, tob(nm));
    rdchk("R7 yr",  A_YR,  tob(ny));
    wr(A_CTL, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    wait_n(3);
    rst_n = 1'b1;
    // R2 reset state
    rdchk("R2 rst ctl", A_CTL, 8'h00);
    rdchk("R2 rst sec", A_SEC, 8'h00);
    rdchk("R2 rst dow", A_DOW, 8'h01);
    rdchk("R2 rst date", A_DAT, 8'h01);
    rdchk("R2 rst mon", A_MON, 8'h01);
    rdchk("R2 rst yr", A_YR, 8'h00);

    // R1 storage sweep
    for (int a = 0; a < 2040; a++) wr(AW'(a), 8'(a ^ (a >> 3) ^ 8'h5A));
    for (int a = 0; a < 2040; a++) rdchk("R1 ram", AW'(a), 8'(a ^ (a >> 3) ^ 8'h5A));
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; addr = 11'd5;
    #1 chk("R1 oe high", rdata, 8'h00);
    ce_n = 1'b1;

    // R2 control bits read back, low bits zero
    wr(A_CTL, 8'hFF);
    rdchk("R2 ctl", A_CTL, 8'hC0);
    wr(A_CTL, 8'h00);

    // R13 first advance timing after load, R8 follow
    set_time(8'h30, 8'h06, 8'h10, 8'h03, 8'h12, 8'h34, 8'h20);
    wait_n(1);
    rdchk("R10 load", A_SEC, 8'h20);
    wait_n(DIV - 1);
    rdchk("R13 before", A_SEC, 8'h20);
    wait_n(1);
    rdchk("R13 R8 after", A_SEC, 8'h21);

    // R10 time write without hold ignored
    set_time(8'h30, 8'h06, 8'h10, 8'h03, 8'h12, 8'h34, 8'h20);
    wr(A_SEC, 8'h45);
    wait_n(1);
    rdchk("R10 ignored", A_SEC, 8'h20);

    // R9 freeze keeps counting underneath
    set_time(8'h30, 8'h06, 8'h10, 8'h03, 8'h12, 8'h34, 8'h10);
    wr(A_CTL, 8'h40);
    wait_n(3 * DIV);
    rdchk("R9 frozen", A_SEC, 8'h10);
    wr(A_CTL, 8'h00);
    wait_n(1);
    rdchk("R9 elapsed", A_SEC, 8'h13);

    // R3 multi-advance carry into minutes
    set_time(8'h30, 8'h06, 8'h10, 8'h03, 8'h00, 8'h00, 8'h50);
    wait_n(12 * DIV + 3);
    wr(A_CTL, 8'h40);
    rdchk("R3 min carry", A_MIN, 8'h01);
    rdchk("R3 sec count", A_SEC, 8'h02);
    wr(A_CTL, 8'h00);

    // R11 stop flag
    set_time(8'h30, 8'h06, 8'h10, 8'h03, 8'h00, 8'h00, 8'h85);
    wait_n(3 * DIV);
    rdchk("R11 stopped", A_SEC, 8'h85);

    // R5 R6 month ends, non-leap and leap years
    for (int y = 23; y <= 24; y++)
      for (int m = 1; m <= 12; m++) day_case(y, m, dim(m, y), (m % 7) + 1);
    day_case(0, 2, 28, 7);   // R6 year 00 leap
    day_case(0, 2, 29, 3);
    day_case(41, 3, 15, 2);  // mid-month
    day_case(99, 12, 31, 7); // R7 century wrap

    // R12 supply fail
    wr(11'd9, 8'hAA);
    pf = 1'b1;
    wr(11'd9, 8'h55);
    wr(A_CTL, 8'h80);
    rd(11'd9, d);
    chk("R12 read quiet", d, 8'h00);
    pf = 1'b0;
    rdchk("R12 ram kept", 11'd9, 8'hAA);
    rdchk("R12 ctl kept", A_CTL, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule